// File: doc/BRIEF.md
# Serial ADC Device-Side Frame Sequencer

This block is the digital frame controller that sits behind the serial pins of a multichannel sampling converter. While chip select is low it counts serial-clock cycles. It gathers an 8-bit command word from the data input on rising edges and, at fixed cycle counts, takes the channel number, opens the acquisition window, fixes the sample instant and starts sending the result. The conversion itself happens outside this block. A 14-bit parallel sample bus is captured at the sample instant, and that captured value is the result that gets shifted out.

A transfer-width pin is read at the falling edge of chip select. It picks between byte-wide framing and word-wide framing. In word-wide framing the acquisition window lasts eight serial cycles longer, and the result starts eight cycles later. The result leaves as a 16-bit field, most significant bit first, made of the 14 result bits followed by two zeros. Any clocks after that field shift out zeros. If chip select rises during a conversion, the conversion is abandoned and the block enters shutdown.

The pins are sampled by a system clock through a synchronizer. Every event therefore appears a few system-clock cycles after the pin edge that causes it.

Top module: `adc_seq_frame`

## Requirements
- R1: While the synchronized chip select is high, `dout_oe` is 0. Within a few system clocks after chip select falls, `dout_oe` is 1 and `dout` is 0. Every frame starts its serial-cycle count at 1, whatever happened in the frame before.
- R2: On the first 8 serial-clock rising edges the data input is shifted into the command word, first bit as bit 7. On the 8th rising edge, in both width modes, `cfg_word` takes the full word and `cfg_done` rises. `cfg_done` is cleared when chip select falls.
- R3: `chan_sel` takes command bits 6 and 5 (the 2nd and 3rd bits received, bit 6 as the MSB) on the 3rd rising edge. It holds that value until the 3rd rising edge of a later frame.
- R4: `acquiring` rises on the 3rd rising edge of the frame.
- R5: With `wide_mode` = 0 latched, the 6th falling edge clears `acquiring`, sets `converting` and captures `sample_in` as the result.
- R6: With `wide_mode` = 1 latched, the same three events happen on the 14th falling edge.
- R7: With `wide_mode` = 0, falling edges 8 through 23 put the bits of {result, 2'b00} on `dout`, MSB first.
- R8: With `wide_mode` = 1, falling edges 16 through 31 put the same 16-bit field on `dout`, MSB first.
- R9: `converting` falls on the falling edge that puts the first result bit on `dout`.
- R10: Every falling edge after the 16-bit field, up to chip select rising, drives `dout` to 0.
- R11: `dout` changes only on serial-clock falling edges and on chip-select falling edges. It never changes on a rising edge.
- R12: Reset puts the block in shutdown (`shutdown` = 1). A chip-select falling edge clears shutdown. If chip select rises while `converting` is 1, `converting` and `acquiring` clear and `shutdown` becomes 1. If chip select rises at any other time, `shutdown` stays 0.
- R13: `wide_mode` is read only at the falling edge of chip select. Changes to it during a frame have no effect on that frame's timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial command data |
| wide_mode | input | 1 | Transfer width: 0 byte framing, 1 word framing |
| sample_in | input | 14 | Parallel conversion result from the converter core |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for `dout` (0 means high impedance) |
| chan_sel | output | 2 | Selected input channel |
| acquiring | output | 1 | Acquisition window open |
| converting | output | 1 | Conversion in progress |
| shutdown | output | 1 | Analog section powered down |
| cfg_word | output | 8 | Last complete command word |
| cfg_done | output | 1 | Command word complete for this frame |

## Verification
Each pin change passes through two synchronizer stages and one edge-detect stage before the register it affects updates. A result is therefore due three system clocks after the pin moves. The bench holds every serial-clock level for eight system clocks and samples at the end of each half period, which is always after that latency and before the next pin change. After each rising edge it checks that `dout` has not moved. After each falling edge it recomputes, from the cycle number and the latched mode, the expected `acquiring`, `converting` and `dout` values. The sample bus is changed right after the sample edge, so a late capture would show up in the shifted result.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ACQ  = 2'd1,
      PH_CONV = 2'd2,
      PH_READ = 2'd3
   } frame_phase_t;

   function automatic int pick_cycle(input logic wide, input int narrow_c, input int wide_c);
      return wide ? wide_c : narrow_c;
   endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("adc_seq_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain[s] <= RST_VAL;
            end else begin
               if (s == 0) chain[s] <= d;
               else        chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/adc_seq_edge.sv
module adc_seq_edge #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_s,
   input  logic             sclk_s,
   output logic             rise_ev,
   output logic             fall_ev,
   output logic             cs_fall,
   output logic             cs_rise,
   output logic [CNT_W-1:0] cyc
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic sclk_p;
   logic cs_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_p <= 1'b0;
         cs_p   <= 1'b1;
      end else begin
         sclk_p <= sclk_s;
         cs_p   <= cs_s;
      end
   end

   assign rise_ev = sclk_s & ~sclk_p & ~cs_s;
   assign fall_ev = ~sclk_s & sclk_p & ~cs_s;
   assign cs_fall = ~cs_s & cs_p;
   assign cs_rise = cs_s & ~cs_p;

   // count of rising edges seen in the current frame (saturating)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc <= '0;
      end else if (cs_s) begin
         cyc <= '0;
      end else if (rise_ev && (cyc != CNT_MAX)) begin
         cyc <= cyc + 1'b1;
      end
   end

endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
   parameter int CMD_W   = 8,
   parameter int CH_W    = 2,
   parameter int RES_W   = 14,
   parameter int FIELD_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_fall,
   input  logic               din_s,
   input  logic               cmd_shift,
   input  logic               chan_ld,
   input  logic               cfg_ld,
   input  logic               cap,
   input  logic               out_ld,
   input  logic               out_sh,
   input  logic [RES_W-1:0]   sample_in,
   output logic [CH_W-1:0]    chan_sel,
   output logic [CMD_W-1:0]   cfg_word,
   output logic               cfg_done,
   output logic               dout
);
   localparam int PAD_W = FIELD_W - RES_W;

   logic [CMD_W-1:0]   cmd_q;
   logic [CMD_W-1:0]   cmd_nxt;
   logic [RES_W-1:0]   res_q;
   logic [FIELD_W-1:0] field;
   logic [FIELD_W-1:0] sh_q;

   assign cmd_nxt = {cmd_q[CMD_W-2:0], din_s};

   generate
      if (PAD_W == 0) begin : g_nopad
         assign field = res_q;
      end else begin : g_pad
         assign field = {res_q, {PAD_W{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         chan_sel <= '0;
         cfg_word <= '0;
         cfg_done <= 1'b0;
      end else if (cs_fall) begin
         cmd_q    <= '0;
         cfg_done <= 1'b0;
      end else begin
         if (cmd_shift) cmd_q <= cmd_nxt;
         if (chan_ld)   chan_sel <= cmd_nxt[CH_W-1:0];
         if (cfg_ld) begin
            cfg_word <= cmd_nxt;
            cfg_done <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
      end else if (cap) begin
         res_q <= sample_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (cs_fall) begin
         sh_q <= '0;
      end else if (out_ld) begin
         sh_q <= field;
      end else if (out_sh) begin
         sh_q <= {sh_q[FIELD_W-2:0], 1'b0};
      end
   end

   assign dout = sh_q[FIELD_W-1];

endmodule

// File: rtl/adc_seq_frame.sv
module adc_seq_frame
   import adc_seq_pkg::*;
#(
   parameter int RES_W    = 14,
   parameter int FIELD_W  = 16,
   parameter int CMD_W    = 8,
   parameter int CH_W     = 2,
   parameter int SYNC_N   = 2,
   parameter int CNT_W    = 6,
   parameter int SAMP_N8  = 6,
   parameter int SAMP_N16 = 14,
   parameter int OUT_N8   = 8,
   parameter int OUT_N16  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sclk,
   input  logic             din,
   input  logic             wide_mode,
   input  logic [RES_W-1:0] sample_in,
   output logic             dout,
   output logic             dout_oe,
   output logic [CH_W-1:0]  chan_sel,
   output logic             acquiring,
   output logic             converting,
   output logic             shutdown,
   output logic [CMD_W-1:0] cfg_word,
   output logic             cfg_done
);
   localparam int CHAN_N = 1 + CH_W;
   localparam int CFG_N  = CMD_W;

   generate
      if (RES_W > FIELD_W) begin : g_bad_field
         $error("adc_seq_frame: RES_W exceeds FIELD_W");
      end
      if (CMD_W < CHAN_N) begin : g_bad_cmd
         $error("adc_seq_frame: command word too short for channel field");
      end
      if ((SAMP_N8 >= OUT_N8) || (SAMP_N16 >= OUT_N16)) begin : g_bad_order
         $error("adc_seq_frame: sample cycle must precede first output cycle");
      end
      if ((SAMP_N8 <= CHAN_N) || (SAMP_N16 <= CHAN_N)) begin : g_bad_acq
         $error("adc_seq_frame: sample cycle must follow channel cycle");
      end
      if ((OUT_N16 + FIELD_W) >= (1 << CNT_W)) begin : g_bad_cnt
         $error("adc_seq_frame: CNT_W too small for frame length");
      end
   endgenerate

   // ---------------- pin synchronization ----------------
   logic [3:0] pins_raw;
   logic [3:0] pins_s;
   logic       cs_s, sclk_s, din_s, mode_s;

   assign pins_raw = {wide_mode, din, sclk, cs_n};

   adc_seq_sync #(
      .W      (4),
      .STAGES (SYNC_N),
      .RST_VAL(4'b0001)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pins_raw),
      .q    (pins_s)
   );

   assign cs_s   = pins_s[0];
   assign sclk_s = pins_s[1];
   assign din_s  = pins_s[2];
   assign mode_s = pins_s[3];

   // ---------------- edge detection and cycle count ----------------
   logic             rise_ev, fall_ev, cs_fall, cs_rise;
   logic [CNT_W-1:0] cyc;
   logic [CNT_W-1:0] rise_idx;

   adc_seq_edge #(.CNT_W(CNT_W)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_s   (cs_s),
      .sclk_s (sclk_s),
      .rise_ev(rise_ev),
      .fall_ev(fall_ev),
      .cs_fall(cs_fall),
      .cs_rise(cs_rise),
      .cyc    (cyc)
   );

   assign rise_idx = cyc + 1'b1;

   // ---------------- mode latch ----------------
   logic mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= 1'b0;
      else if (cs_fall) mode_q <= mode_s;
   end

   logic [CNT_W-1:0] samp_c;
   logic [CNT_W-1:0] out_c;

   assign samp_c = CNT_W'(pick_cycle(mode_q, SAMP_N8, SAMP_N16));
   assign out_c  = CNT_W'(pick_cycle(mode_q, OUT_N8, OUT_N16));

   // ---------------- event strobes ----------------
   logic cmd_shift, chan_ld, cfg_ld, samp_ev, out_ld, out_sh;

   assign cmd_shift = rise_ev && (rise_idx <= CNT_W'(CMD_W));
   assign chan_ld   = rise_ev && (rise_idx == CNT_W'(CHAN_N));
   assign cfg_ld    = rise_ev && (rise_idx == CNT_W'(CFG_N));
   assign samp_ev   = fall_ev && (cyc == samp_c);
   assign out_ld    = fall_ev && (cyc == out_c);
   assign out_sh    = fall_ev && (cyc >  out_c);

   // ---------------- frame phase ----------------
   frame_phase_t phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
      end else if (cs_rise || cs_fall) begin
         phase_q <= PH_IDLE;
      end else begin
         case (phase_q)
            PH_IDLE: if (chan_ld) phase_q <= PH_ACQ;
            PH_ACQ:  if (samp_ev) phase_q <= PH_CONV;
            PH_CONV: if (out_ld)  phase_q <= PH_READ;
            default: phase_q <= phase_q;
         endcase
      end
   end

   assign acquiring  = (phase_q == PH_ACQ);
   assign converting = (phase_q == PH_CONV);

   // ---------------- power state and output enable ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shutdown <= 1'b1;
      end else if (cs_fall) begin
         shutdown <= 1'b0;
      end else if (cs_rise && converting) begin
         shutdown <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout_oe <= 1'b0;
      else        dout_oe <= ~cs_s;
   end

   // ---------------- data path ----------------
   adc_seq_shift #(
      .CMD_W  (CMD_W),
      .CH_W   (CH_W),
      .RES_W  (RES_W),
      .FIELD_W(FIELD_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_fall  (cs_fall),
      .din_s    (din_s),
      .cmd_shift(cmd_shift),
      .chan_ld  (chan_ld),
      .cfg_ld   (cfg_ld),
      .cap      (samp_ev),
      .out_ld   (out_ld),
      .out_sh   (out_sh),
      .sample_in(sample_in),
      .chan_sel (chan_sel),
      .cfg_word (cfg_word),
      .cfg_done (cfg_done),
      .dout     (dout)
   );

endmodule

// File: rtl/adc_seq_frame_chk.sv
module adc_seq_frame_chk #(
   parameter int CH_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rise_ev,
   input logic            fall_ev,
   input logic            cs_fall,
   input logic            cs_rise,
   input logic            chan_ld,
   input logic            dout,
   input logic [CH_W-1:0] chan_sel,
   input logic            acquiring,
   input logic            converting,
   input logic            shutdown
);
   p_dout_fall_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall_ev && !cs_fall) |=> $stable(dout));

   p_chan_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_ld |=> $stable(chan_sel));

   p_abort_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && converting) |=> (shutdown && !converting));

   p_acq_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acquiring) |-> $past(rise_ev));

   p_conv_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(converting) |-> ($past(fall_ev) && !acquiring));

endmodule

bind adc_seq_frame adc_seq_frame_chk #(.CH_W(CH_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rise_ev   (rise_ev),
   .fall_ev   (fall_ev),
   .cs_fall   (cs_fall),
   .cs_rise   (cs_rise),
   .chan_ld   (chan_ld),
   .dout      (dout),
   .chan_sel  (chan_sel),
   .acquiring (acquiring),
   .converting(converting),
   .shutdown  (shutdown)
);

// File: tb/tb_adc_seq_frame.sv
module tb_adc_seq_frame;
   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b0;
   logic        din = 1'b0;
   logic        wide_mode = 1'b0;
   logic [13:0] sample_in = '0;
   logic        dout, dout_oe, acquiring, converting, shutdown, cfg_done;
   logic [1:0]  chan_sel;
   logic [7:0]  cfg_word;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   adc_seq_frame dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .wide_mode(wide_mode), .sample_in(sample_in), .dout(dout),
      .dout_oe(dout_oe), .chan_sel(chan_sel), .acquiring(acquiring),
      .converting(converting), .shutdown(shutdown), .cfg_word(cfg_word),
      .cfg_done(cfg_done)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic settle();
      repeat (HALF) @(negedge clk);
   endtask

   // abort_at = 0 means no abort; otherwise chip select rises after that falling edge
   task automatic run_frame(input bit wide, input logic [7:0] cmd,
                            input logic [13:0] res, input int abort_at);
      int samp, outc, ncyc;
      logic [15:0] field;
      logic exp_dout, exp_acq, exp_conv;
      string rt;
      samp  = wide ? 14 : 6;
      outc  = wide ? 16 : 8;
      ncyc  = outc + 16 + 4;
      field = {res, 2'b00};
      rt    = wide ? "R8" : "R7";
      exp_dout = 1'b0;

      @(negedge clk);
      cs_n = 1'b0; sclk = 1'b0; wide_mode = wide; sample_in = res;
      settle();
      check("R1", "oe after cs low", 32'(dout_oe), 32'd1);
      check("R1", "dout low after cs low", 32'(dout), 32'd0);
      check("R12", "awake after cs low", 32'(shutdown), 32'd0);
      check("R2", "cfg_done cleared", 32'(cfg_done), 32'd0);
      wide_mode = ~wide;   // R13: mid-frame change must be ignored

      for (int n = 1; n <= ncyc; n++) begin
         din = (n <= 8) ? cmd[8-n] : n[0];
         sclk = 1'b1;
         settle();
         check("R11", "dout held on rise", 32'(dout), 32'(exp_dout));
         if (n == 3) begin
            check("R3", "channel at rise 3", 32'(chan_sel), 32'(cmd[6:5]));
            check("R4", "acquiring at rise 3", 32'(acquiring), 32'd1);
         end
         if (n == 8) begin
            check("R2", "cfg_word at rise 8", 32'(cfg_word), 32'(cmd));
            check("R2", "cfg_done at rise 8", 32'(cfg_done), 32'd1);
         end
         sclk = 1'b0;
         settle();
         if (n == samp) sample_in = ~res;   // a late capture would corrupt the result
         exp_acq  = (n >= 3) && (n < samp);
         exp_conv = (n >= samp) && (n < outc);
         exp_dout = (n >= outc && n < outc + 16) ? field[15-(n-outc)] : 1'b0;
         check(wide ? "R6" : "R5", "acquiring after fall", 32'(acquiring), 32'(exp_acq));
         check(n == outc ? "R9" : (wide ? "R6" : "R5"), "converting after fall",
               32'(converting), 32'(exp_conv));
         check(n >= outc + 16 ? "R10" : (n >= outc ? rt : "R13"), "dout after fall",
               32'(dout), 32'(exp_dout));
         if (abort_at == n) begin
            @(negedge clk);
            cs_n = 1'b1;
            settle();
            check("R12", "converting cleared on abort", 32'(converting), 32'd0);
            check("R12", "acquiring cleared on abort", 32'(acquiring), 32'd0);
            check("R12", "shutdown on abort", 32'(shutdown), 32'd1);
            check("R1", "oe off on abort", 32'(dout_oe), 32'd0);
            return;
         end
      end
      check("R3", "channel held to frame end", 32'(chan_sel), 32'(cmd[6:5]));
      @(negedge clk);
      cs_n = 1'b1;
      settle();
      check("R1", "oe off after cs high", 32'(dout_oe), 32'd0);
      check("R12", "no shutdown on normal end", 32'(shutdown), 32'd0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      settle();
      check("R12", "reset shutdown", 32'(shutdown), 32'd1);
      check("R1", "reset oe", 32'(dout_oe), 32'd0);
      check("R4", "reset acquiring", 32'(acquiring), 32'd0);
      check("R5", "reset converting", 32'(converting), 32'd0);

      for (int m = 0; m < 2; m++) begin
         for (int ch = 0; ch < 4; ch++) begin
            for (int k = 0; k < 4; k++) begin
               logic [13:0] r;
               logic [7:0]  c;
               r = (k == 0) ? 14'h3FFF : (k == 1) ? 14'h0000
                                        : 14'((ch * 4919 + k * 3001 + m * 777) & 16'h3FFF);
               c = {1'b1, 2'(ch), 5'((k * 7 + m * 3 + ch) & 31)};
               run_frame(m[0], c, r, 0);
            end
         end
      end
      run_frame(1'b0, 8'hA5, 14'h1234, 7);
      run_frame(1'b0, 8'hC3, 14'h2AAA, 0);   // R12: shutdown cleared again
      run_frame(1'b1, 8'h3C, 14'h1555, 15);
      run_frame(1'b1, 8'hE1, 14'h0F0F, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule